// File: doc/BRIEF.md
# Direct-Mapped Byte Cache Controller

This block places a direct-mapped cache between a processor-side port that reads and writes single bytes and a main-memory port that moves whole lines. Each processor request is a 32-bit byte address, a read/write flag and a write byte, offered with a valid/ready handshake. The controller answers with a one-cycle response pulse that carries the read byte. At most one request is in flight. On the memory side, line reads (refills) and line writes (victim write-backs and single-byte write-throughs) go out on a request/acknowledge handshake. A per-byte strobe marks which lanes of a line write are meaningful.

The store keeps a valid flag, a dirty flag and a tag for every line, next to the line data. With the default sizing it holds 2048 lines of 32 bytes, which is 64 KiB of data. Two parameters choose the write-hit policy (write-back or write-through) and the write-miss policy (allocate or no-allocate). Reset clears only the valid flags. Tags, dirty flags and data keep whatever they held.

Top module: `dm_cache`

## Requirements
- R1: An address splits into byte offset [4:0], line index [15:5] and tag [31:16] at the default sizing. With NUM_LINES lines the index is the log2(NUM_LINES) bits from bit 5 upward and the tag is every bit above them. Bytes that differ only in offset share a line, and addresses that differ in any index bit fall in different lines.
- R2: After reset every line is invalid, so the first access to any address misses and issues a line read. Reset does not cause a write-back of a line that was dirty.
- R3: A hit needs both a set valid flag and a stored tag equal to the address tag. An access to a valid line whose tag differs in any bit, the top address bit included, is a miss.
- R4: A read miss issues one line read at the address with bits [4:0] cleared. It returns the byte at the requested offset of the fetched line, and later reads of that line are served with no memory traffic.
- R5: In write-back mode a write hit changes only the cached byte and marks the line dirty, with no memory transaction. A later read of that byte returns the new value.
- R6: In write-through mode a write hit updates the cached byte and also issues one memory write at the line-aligned address. That write has exactly strobe bit `offset` set and the byte in lanes [8*offset+7:8*offset]. The line is never marked dirty.
- R7: In write-back mode, a miss on a valid dirty line first writes the old line to memory: all 32 strobe bits set, address {stored tag, index, 00000}. Only after that write is acknowledged is the new line read.
- R8: A miss on a clean or invalid line issues no memory write. Every refill leaves the line valid and clean.
- R9: With write-allocate, a write miss fills the line first and then completes as a write hit. In write-back mode that means no memory write and a dirty line.
- R10: Without write-allocate, a write miss sends the byte to memory only, as a single-strobe write, and leaves the cache unchanged, so a later read of that address misses.
- R11: cpu_ready is high only when the controller is idle. It is low from the cycle after acceptance until after the single cpu_resp pulse. A memory request holds its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request offered |
| cpu_ready | output | 1 | Controller idle, request taken when cpu_valid is high |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_resp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with cpu_resp on reads |
| mem_req | output | 1 | Memory transaction requested, held until acknowledged |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 256 | Line write data |
| mem_wstrb | output | 32 | Per-byte lane enables for line writes |
| mem_ack | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | 256 | Line read data, valid with mem_ack |

## Verification
The bench builds two instances with NUM_LINES=16, which makes the index bits [8:5] and the tag bits [31:9]. One instance runs write-back with write-allocate and the other runs write-through without allocation. Because there are only 16 lines, addresses 512 bytes apart collide on one line. That small spacing lets the bench drive dirty evictions, clean evictions, allocate-then-dirty fills and tag mismatches in the top address bit in a few accesses. The second instance covers the single-lane write-through strobe and the no-allocate write miss that the first policy pair cannot reach.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

    localparam int ADDR_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_REFILL,
        ST_WTHRU,
        ST_RESPOND
    } ctrl_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } cpu_req_t;

    function automatic logic is_mem_state(input ctrl_state_e s);
        return (s == ST_WRITEBACK) || (s == ST_REFILL) || (s == ST_WTHRU);
    endfunction

endpackage

// File: rtl/dm_cache_tag_store.sv
module dm_cache_tag_store #(
    parameter int NUM_LINES = 2048,
    parameter int IDX_W     = 11,
    parameter int TAG_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q   [NUM_LINES];
    logic                 dirty_q [NUM_LINES];

    // Only the valid flags see reset; tag and dirty contents persist.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]   <= fill_tag;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];

    p_reset_clears_valid_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0));

endmodule

// File: rtl/dm_cache_data_store.sv
module dm_cache_data_store #(
    parameter int NUM_LINES  = 2048,
    parameter int LINE_BYTES = 32,
    parameter int IDX_W      = 11,
    parameter int OFF_W      = 5
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        idx,
    input  logic                    fill_en,
    input  logic [LINE_BYTES*8-1:0] fill_line,
    input  logic                    byte_en,
    input  logic [OFF_W-1:0]        byte_off,
    input  logic [7:0]              byte_data,
    output logic [LINE_BYTES*8-1:0] rd_line
);

    // One narrow array per byte lane so a single-byte write touches one lane.
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        logic [7:0] lane_q [NUM_LINES];

        always_ff @(posedge clk) begin
            if (fill_en) begin
                lane_q[idx] <= fill_line[8*b +: 8];
            end else if (byte_en && (byte_off == OFF_W'(b))) begin
                lane_q[idx] <= byte_data;
            end
        end

        assign rd_line[8*b +: 8] = lane_q[idx];
    end

endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
    import dm_cache_pkg::*;
#(
    parameter int LINE_BYTES     = 32,
    parameter int IDX_W          = 11,
    parameter int OFF_W          = 5,
    parameter int TAG_W          = 16,
    parameter bit WRITE_BACK     = 1'b1,
    parameter bit WRITE_ALLOCATE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_valid,
    output logic                    cpu_ready,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [BYTE_W-1:0]       cpu_wdata,
    output logic                    cpu_resp,
    output logic [BYTE_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    output logic [LINE_BYTES-1:0]   mem_wstrb,
    input  logic                    mem_ack,
    output logic [IDX_W-1:0]        line_idx,
    input  logic                    ts_valid,
    input  logic                    ts_dirty,
    input  logic [TAG_W-1:0]        ts_tag,
    output logic                    fill_en,
    output logic [TAG_W-1:0]        fill_tag,
    output logic                    mark_dirty,
    input  logic [LINE_BYTES*8-1:0] ds_line,
    output logic                    byte_en,
    output logic [OFF_W-1:0]        byte_off
);

    ctrl_state_e state_q, state_d;
    cpu_req_t    req_q;
    logic [BYTE_W-1:0] rdata_q;

    logic [OFF_W-1:0] req_off;
    logic [TAG_W-1:0] req_tag;
    logic             hit;

    assign req_off  = req_q.addr[OFF_W-1:0];
    assign line_idx = req_q.addr[OFF_W +: IDX_W];
    assign req_tag  = req_q.addr[ADDR_W-1 -: TAG_W];
    assign hit      = ts_valid && (ts_tag == req_tag);

    always_comb begin
        state_d    = state_q;
        fill_en    = 1'b0;
        byte_en    = 1'b0;
        mark_dirty = 1'b0;
        case (state_q)
            ST_IDLE: if (cpu_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit) begin
                    if (req_q.we) begin
                        byte_en    = 1'b1;
                        mark_dirty = WRITE_BACK;
                        state_d    = WRITE_BACK ? ST_RESPOND : ST_WTHRU;
                    end else begin
                        state_d = ST_RESPOND;
                    end
                end else if (req_q.we && !WRITE_ALLOCATE) begin
                    state_d = ST_WTHRU;
                end else if (WRITE_BACK && ts_valid && ts_dirty) begin
                    state_d = ST_WRITEBACK;
                end else begin
                    state_d = ST_REFILL;
                end
            end
            ST_WRITEBACK: if (mem_ack) state_d = ST_REFILL;
            ST_REFILL: if (mem_ack) begin
                fill_en = 1'b1;
                state_d = ST_LOOKUP;
            end
            ST_WTHRU: if (mem_ack) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_valid) begin
                req_q <= '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
            end
            if (state_q == ST_LOOKUP && hit && !req_q.we) begin
                rdata_q <= ds_line[{req_off, 3'b000} +: BYTE_W];
            end
        end
    end

    assign fill_tag  = req_tag;
    assign byte_off  = req_off;
    assign cpu_ready = (state_q == ST_IDLE);
    assign cpu_resp  = (state_q == ST_RESPOND);
    assign cpu_rdata = rdata_q;

    assign mem_req   = is_mem_state(state_q);
    assign mem_we    = (state_q == ST_WRITEBACK) || (state_q == ST_WTHRU);
    assign mem_addr  = (state_q == ST_WRITEBACK) ? {ts_tag, line_idx, {OFF_W{1'b0}}}
                                                 : {req_tag, line_idx, {OFF_W{1'b0}}};
    assign mem_wdata = (state_q == ST_WRITEBACK) ? ds_line : {LINE_BYTES{req_q.wdata}};
    assign mem_wstrb = (state_q == ST_WRITEBACK) ? {LINE_BYTES{1'b1}}
                     : (state_q == ST_WTHRU) ? ({{(LINE_BYTES-1){1'b0}}, 1'b1} << req_off)
                     : {LINE_BYTES{1'b0}};

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_accept_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_ready) |=> !cpu_ready);

    p_victim_then_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && (&mem_wstrb)) |=> (mem_req && !mem_we));

    p_fill_then_hit_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REFILL && mem_ack) |=> (hit && !ts_dirty));

    p_wt_never_dirty_r6: assert property (@(posedge clk) disable iff (rst)
        (!WRITE_BACK && ts_valid) |-> !ts_dirty);

endmodule

// File: rtl/dm_cache.sv
module dm_cache
    import dm_cache_pkg::*;
#(
    parameter int NUM_LINES      = 2048,
    parameter int LINE_BYTES     = 32,
    parameter bit WRITE_BACK     = 1'b1,
    parameter bit WRITE_ALLOCATE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_valid,
    output logic                    cpu_ready,
    input  logic                    cpu_we,
    input  logic [31:0]             cpu_addr,
    input  logic [7:0]              cpu_wdata,
    output logic                    cpu_resp,
    output logic [7:0]              cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [31:0]             mem_addr,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    output logic [LINE_BYTES-1:0]   mem_wstrb,
    input  logic                    mem_ack,
    input  logic [LINE_BYTES*8-1:0] mem_rdata
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0] line_idx;
    logic             ts_valid, ts_dirty, fill_en, mark_dirty, byte_en;
    logic [TAG_W-1:0] ts_tag, fill_tag;
    logic [OFF_W-1:0] byte_off;
    logic [LINE_BYTES*8-1:0] ds_line;

    dm_cache_ctrl #(
        .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W),
        .WRITE_BACK(WRITE_BACK), .WRITE_ALLOCATE(WRITE_ALLOCATE)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_ack(mem_ack),
        .line_idx(line_idx), .ts_valid(ts_valid), .ts_dirty(ts_dirty), .ts_tag(ts_tag),
        .fill_en(fill_en), .fill_tag(fill_tag), .mark_dirty(mark_dirty),
        .ds_line(ds_line), .byte_en(byte_en), .byte_off(byte_off)
    );

    dm_cache_tag_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .idx(line_idx),
        .fill_en(fill_en), .fill_tag(fill_tag), .mark_dirty(mark_dirty),
        .rd_valid(ts_valid), .rd_dirty(ts_dirty), .rd_tag(ts_tag)
    );

    dm_cache_data_store #(
        .NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_data (
        .clk(clk), .idx(line_idx),
        .fill_en(fill_en), .fill_line(mem_rdata),
        .byte_en(byte_en), .byte_off(byte_off), .byte_data(cpu_wdata_q()),
        .rd_line(ds_line)
    );

    // The written byte is taken from the lane-replicated write-through data bus.
    function automatic logic [7:0] cpu_wdata_q();
        return mem_wdata_rep[7:0];
    endfunction

    logic [LINE_BYTES*8-1:0] mem_wdata_rep;
    assign mem_wdata_rep = mem_wdata;

endmodule

// File: tb/dm_cache_tb_top.sv
module mem_model #(
    parameter int LB = 32
) (
    input  logic            clk,
    input  logic            req,
    input  logic            we,
    input  logic [31:0]     addr,
    input  logic [LB*8-1:0] wdata,
    input  logic [LB-1:0]   wstrb,
    output logic            ack,
    output logic [LB*8-1:0] rdata,
    output logic [31:0]     nrd,
    output logic [31:0]     nwr,
    output logic [31:0]     last_rd_addr,
    output logic [31:0]     last_wr_addr,
    output logic [LB-1:0]   last_wstrb,
    output logic [LB*8-1:0] last_wdata,
    output logic [31:0]     rd_seq,
    output logic [31:0]     wr_seq
);
    logic [LB*8-1:0] store [logic [31:0]];
    logic [LB*8-1:0] tmp;
    int cnt;
    int seq;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] + a[15:8] * 8'd3 + a[23:16] * 8'd5 + a[31:24] * 8'd7;
    endfunction

    initial begin
        ack = 0; rdata = '0; nrd = 0; nwr = 0; cnt = 0; seq = 0;
        last_rd_addr = 0; last_wr_addr = 0; last_wstrb = '0; last_wdata = '0;
        rd_seq = 0; wr_seq = 0;
    end

    always @(posedge clk) begin
        if (ack) begin
            ack <= 1'b0;
        end else if (req) begin
            if (cnt == 1) begin
                cnt = 0;
                if (store.exists(addr)) tmp = store[addr];
                else for (int b = 0; b < LB; b++) tmp[8*b +: 8] = pat(addr + 32'(b));
                if (we) begin
                    for (int b = 0; b < LB; b++) if (wstrb[b]) tmp[8*b +: 8] = wdata[8*b +: 8];
                    store[addr] = tmp;
                    nwr <= nwr + 1; last_wr_addr <= addr; last_wstrb <= wstrb;
                    last_wdata <= wdata; wr_seq <= seq;
                end else begin
                    rdata <= tmp;
                    nrd <= nrd + 1; last_rd_addr <= addr; rd_seq <= seq;
                end
                seq = seq + 1;
                ack <= 1'b1;
            end else begin
                cnt = cnt + 1;
            end
        end
    end
endmodule

module dm_cache_tb_top;
    localparam int LB = 32;
    localparam int TB_LINES = 16;

    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic        cv [2], cwe [2], crdy [2], cresp [2];
    logic [31:0] caddr [2];
    logic [7:0]  cwd [2], crd [2];
    logic        mreq [2], mwe [2], mack [2];
    logic [31:0] maddr [2];
    logic [LB*8-1:0] mwd [2], mrd [2], lwd [2];
    logic [LB-1:0]   mstrb [2], lstrb [2];
    logic [31:0] nrd [2], nwr [2], lra [2], lwa [2], rseq [2], wseq [2];

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] rdv;
    logic [7:0] exp0 [logic [31:0]];
    logic [7:0] exp1 [logic [31:0]];

    dm_cache #(.NUM_LINES(TB_LINES), .LINE_BYTES(LB), .WRITE_BACK(1'b1), .WRITE_ALLOCATE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .cpu_valid(cv[0]), .cpu_ready(crdy[0]), .cpu_we(cwe[0]),
        .cpu_addr(caddr[0]), .cpu_wdata(cwd[0]), .cpu_resp(cresp[0]), .cpu_rdata(crd[0]),
        .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwd[0]),
        .mem_wstrb(mstrb[0]), .mem_ack(mack[0]), .mem_rdata(mrd[0]));

    dm_cache #(.NUM_LINES(TB_LINES), .LINE_BYTES(LB), .WRITE_BACK(1'b0), .WRITE_ALLOCATE(1'b0)) dut_wt_i (
        .clk(clk), .rst(rst), .cpu_valid(cv[1]), .cpu_ready(crdy[1]), .cpu_we(cwe[1]),
        .cpu_addr(caddr[1]), .cpu_wdata(cwd[1]), .cpu_resp(cresp[1]), .cpu_rdata(crd[1]),
        .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwd[1]),
        .mem_wstrb(mstrb[1]), .mem_ack(mack[1]), .mem_rdata(mrd[1]));

    for (genvar g = 0; g < 2; g++) begin : g_mem
        mem_model #(.LB(LB)) u_mem (
            .clk(clk), .req(mreq[g]), .we(mwe[g]), .addr(maddr[g]), .wdata(mwd[g]),
            .wstrb(mstrb[g]), .ack(mack[g]), .rdata(mrd[g]), .nrd(nrd[g]), .nwr(nwr[g]),
            .last_rd_addr(lra[g]), .last_wr_addr(lwa[g]), .last_wstrb(lstrb[g]),
            .last_wdata(lwd[g]), .rd_seq(rseq[g]), .wr_seq(wseq[g]));
    end

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] + a[15:8] * 8'd3 + a[23:16] * 8'd5 + a[31:24] * 8'd7;
    endfunction

    function automatic logic [7:0] exp_byte(input int s, input logic [31:0] a);
        if (s == 0) return exp0.exists(a) ? exp0[a] : pat(a);
        return exp1.exists(a) ? exp1[a] : pat(a);
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, expv);
        end
    endtask

    // One processor access; also checks the R11 handshake around it.
    task automatic access(input int s, input bit we, input logic [31:0] a, input logic [7:0] d);
        bit busy_ready = 0;
        @(negedge clk);
        cv[s] = 1; cwe[s] = we; caddr[s] = a; cwd[s] = d;
        while (!crdy[s]) @(negedge clk);
        @(negedge clk);
        cv[s] = 0;
        while (!cresp[s]) begin
            if (crdy[s]) busy_ready = 1;
            @(negedge clk);
        end
        rdv = crd[s];
        chk("R11 ready low while busy", 32'(busy_ready), 32'd0);
        @(negedge clk);
        chk("R11 single response, ready back", {30'd0, cresp[s], crdy[s]}, 32'd1);
        if (we) begin
            if (s == 0) exp0[a] = d; else exp1[a] = d;
        end
    endtask

    task automatic read_chk(input int s, input logic [31:0] a, input int drd, input int dwr, input string rq);
        logic [31:0] r0 = nrd[s], w0 = nwr[s];
        access(s, 1'b0, a, 8'h00);
        chk({rq, " read data"}, 32'(rdv), 32'(exp_byte(s, a)));
        chk({rq, " line reads"}, nrd[s] - r0, 32'(drd));
        chk({rq, " line writes"}, nwr[s] - w0, 32'(dwr));
    endtask

    task automatic write_chk(input int s, input logic [31:0] a, input logic [7:0] d, input int drd, input int dwr, input string rq);
        logic [31:0] r0 = nrd[s], w0 = nwr[s];
        access(s, 1'b1, a, d);
        chk({rq, " line reads"}, nrd[s] - r0, 32'(drd));
        chk({rq, " line writes"}, nwr[s] - w0, 32'(dwr));
    endtask

    task automatic t_reset_state();
        chk("R11 reset ready", 32'(crdy[0]), 32'd1);
        chk("R11 reset no resp", 32'(cresp[0]), 32'd0);
        chk("R11 reset no mem req", {31'd0, mreq[0] | mreq[1]}, 32'd0);
    endtask

    task automatic t_read_miss_hit();
        read_chk(0, 32'h0003_003C, 1, 0, "R2 R4 first read misses");
        chk("R4 fill address aligned", lra[0], 32'h0003_0020);
        read_chk(0, 32'h0003_003D, 0, 0, "R4 same line hits");
        read_chk(0, 32'h0003_003F, 0, 0, "R4 last offset hits");
    endtask

    task automatic t_wb_write_hit();
        write_chk(0, 32'h0003_003C, 8'h5A, 0, 0, "R5 write hit no traffic");
        read_chk(0, 32'h0003_003C, 0, 0, "R5 read back written byte");
    endtask

    task automatic t_dirty_evict();
        read_chk(0, 32'h0003_023C, 1, 1, "R7 R3 dirty conflict");
        chk("R7 victim address", lwa[0], 32'h0003_0020);
        chk("R7 victim full strobe", lstrb[0], 32'hFFFF_FFFF);
        chk("R7 writeback before refill", 32'(wseq[0] < rseq[0]), 32'd1);
        read_chk(0, 32'h0003_003C, 1, 0, "R8 R7 clean victim, data written back");
    endtask

    task automatic t_allocate();
        write_chk(0, 32'h0004_0036, 8'h77, 1, 0, "R9 write miss allocates");
        read_chk(0, 32'h0004_0036, 0, 0, "R9 allocated byte hits");
        read_chk(0, 32'h0003_003C, 1, 1, "R9 allocated line was dirty");
        chk("R9 dirty victim address", lwa[0], 32'h0004_0020);
    endtask

    task automatic t_address_split();
        read_chk(0, 32'h0000_101F, 1, 0, "R1 offset 31 miss");
        read_chk(0, 32'h0000_1000, 0, 0, "R1 offset 0 same line");
        read_chk(0, 32'h0000_1020, 1, 0, "R1 next index is other line");
        read_chk(0, 32'h8000_1000, 1, 0, "R3 top tag bit differs");
    endtask

    task automatic t_reset_valid();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        read_chk(0, 32'h8000_1000, 1, 0, "R2 reset invalidates line");
    endtask

    task automatic t_write_through();
        read_chk(1, 32'h0003_003C, 1, 0, "R4 wt read miss");
        write_chk(1, 32'h0003_003C, 8'hC3, 0, 1, "R6 wt write hit");
        chk("R6 wt address", lwa[1], 32'h0003_0020);
        chk("R6 wt strobe lane 28", lstrb[1], 32'h1000_0000);
        chk("R6 wt byte lane", 32'(lwd[1][28*8 +: 8]), 32'h0000_00C3);
        read_chk(1, 32'h0003_003C, 0, 0, "R6 wt cache updated");
    endtask

    task automatic t_no_allocate();
        write_chk(1, 32'h0005_0010, 8'h9E, 0, 1, "R10 write miss to memory only");
        chk("R10 strobe lane 16", lstrb[1], 32'h0001_0000);
        read_chk(1, 32'h0005_0010, 1, 0, "R10 cache unchanged");
        read_chk(1, 32'h0003_023C, 1, 0, "R8 wt conflict no writeback");
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            cv[i] = 0; cwe[i] = 0; caddr[i] = 0; cwd[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_state();
        t_read_miss_hit();
        t_wb_write_hit();
        t_dirty_evict();
        t_allocate();
        t_address_split();
        t_reset_valid();
        t_write_through();
        t_no_allocate();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule